// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-line programmable interrupt controller. Software writes bytes at two offsets of a small window. The block turns these bytes into a multi-word setup sequence and into run-time commands. It keeps the configuration that the rest of the controller uses: the line mask, the vector base, the trigger mode, the cascade setup and the automatic end-of-interrupt flag. It also keeps a flag that selects which status byte a read returns.

The priority unit beside this block supplies the pending-request byte and the in-service byte. For end-of-interrupt commands, the decoder sends back one-cycle strobes carrying a 3-bit line number. Rotation, special-mask and buffering command bits are accepted but have no effect. The role of the controller in a cascade, master or slave, is fixed by a parameter.

Every write takes effect at the next rising clock edge. Configuration outputs and strobes are registered. Read data is combinational from the address and the read enable.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the mask, vector base, trigger flag, cascade flag, cascade byte and automatic end-of-interrupt flag are all zero. The setup sequencer is idle, a read at offset 0 returns the pending-request byte, and no strobe is active.
- R2: When the sequencer is idle, a write at offset 1 loads the mask with the written byte. A read at offset 1 returns the mask.
- R3: A write at offset 0 with bit 4 set starts setup. It clears the mask, stores bit 3 as the edge-trigger flag and sets the cascade flag to the inverse of bit 1. It records bit 0 as "fourth word due", and the next offset-1 write is taken as setup word 2 rather than as a mask load.
- R4: Setup word 2 sets the vector base to the byte with bits 2:0 forced to zero. Without cascade, it clears the cascade byte and returns the sequencer to idle.
- R5: With cascade, the offset-1 write after word 2 is word 3. A master stores the whole byte as the cascade byte, and a slave stores only bits 2:0. The sequencer then expects word 4 if one was due, and otherwise goes idle.
- R6: Setup word 4 stores its bit 1 as the automatic end-of-interrupt flag and always returns the sequencer to idle. A setup start with bit 0 clear clears that flag.
- R7: A write at offset 0 with bits 4:3 = 00 and bits 7:5 = 001 produces a one-cycle nonspecific strobe in the cycle after the write. The strobe carries the index of the highest set bit of the in-service byte, or 0 if that byte is zero.
- R8: A write at offset 0 with bits 4:3 = 00 and bits 7:5 = 011 produces a one-cycle specific strobe in the cycle after the write, carrying bits 2:0 of the byte as the line.
- R9: A write at offset 0 with bits 4:3 = 00 and any other value of bits 7:5 produces no strobe and changes neither the mask nor the read selection.
- R10: A write at offset 0 with bits 4:3 = 01 and bit 1 set selects the offset-0 read source from bit 0: 1 selects the pending-request byte and 0 selects the in-service byte. With bit 1 clear, the selection is unchanged.
- R11: Writes at offsets other than 0 and 1 change nothing. Reads there return 0x00, and read data is 0x00 whenever the read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-byte write strobe |
| rd_en | input | 1 | Single-byte read strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irr_in | input | 8 | Pending-request byte from the priority unit |
| isr_in | input | 8 | In-service byte from the priority unit |
| mask_o | output | 8 | Line mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| edge_trig_o | output | 1 | Edge-triggered mode |
| cascade_o | output | 1 | Cascade mode |
| casc_cfg_o | output | 8 | Slave-attached lines (master) or own ID (slave) |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt flag |
| eoi_nonspec_o | output | 1 | One-cycle nonspecific end-of-interrupt strobe |
| eoi_spec_o | output | 1 | One-cycle specific end-of-interrupt strobe |
| eoi_line_o | output | 3 | Line number, valid with either strobe |

## Verification
The bench builds two copies with the default 2-bit offset, one as master and one as slave, and drives both with the same stimulus. The slave copy makes the role-dependent word-3 storage visible. The two unused offsets in the window let the bench check that stray accesses are ignored. Because the data path is one byte wide, the bench sweeps all 256 values for mask loads, vector bases and in-service patterns, all eight lines for specific strobes, every command code, and all eight combinations of the three setup-path bits.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int DATA_W = 8;
    localparam int LINE_W = $clog2(DATA_W);

    localparam logic [2:0] OP_EOI_ANY  = 3'b001;
    localparam logic [2:0] OP_EOI_LINE = 3'b011;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_W2   = 2'd1,
        SEQ_W3   = 2'd2,
        SEQ_W4   = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [DATA_W-1:0]   mask;
        logic [DATA_W-1:0]   vec;
        logic                edge_trig;
        logic                cascade;
        logic                w4_due;
        logic [DATA_W-1:0]   casc_cfg;
        logic                auto_eoi;
    } cfg_regs_t;

    typedef struct packed {
        logic                nonspec;
        logic                spec;
        logic [LINE_W-1:0]   line;
        logic                sel_irr;
    } ocw_regs_t;

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] vec_base,
    output logic              edge_trig,
    output logic              cascade,
    output logic [DATA_W-1:0] casc_cfg,
    output logic              auto_eoi,
    output logic              seq_idle
);

    localparam cfg_regs_t CFG_RST = '0;
    localparam logic [DATA_W-1:0] VEC_KEEP = ~DATA_W'((1 << LINE_W) - 1);

    cfg_regs_t r_d, r_q;
    logic [DATA_W-1:0] w3_val;

    // Word 3 storage depends on the role in the cascade
    generate
        if (IS_MASTER) begin : g_master
            assign w3_val = wdata;
        end else begin : g_slave
            assign w3_val = {{(DATA_W-LINE_W){1'b0}}, wdata[LINE_W-1:0]};
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (start_wr) begin
            r_d.mask      = '0;
            r_d.edge_trig = wdata[3];
            r_d.cascade   = ~wdata[1];
            r_d.w4_due    = wdata[0];
            if (!wdata[0]) begin
                r_d.auto_eoi = 1'b0;
            end
            r_d.st = SEQ_W2;
        end else if (data_wr) begin
            case (r_q.st)
                SEQ_IDLE: r_d.mask = wdata;
                SEQ_W2: begin
                    r_d.vec = wdata & VEC_KEEP;
                    if (r_q.cascade) begin
                        r_d.st = SEQ_W3;
                    end else begin
                        r_d.casc_cfg = '0;
                        r_d.st       = SEQ_IDLE;
                    end
                end
                SEQ_W3: begin
                    r_d.casc_cfg = w3_val;
                    r_d.st       = r_q.w4_due ? SEQ_W4 : SEQ_IDLE;
                end
                SEQ_W4: begin
                    r_d.auto_eoi = wdata[1];
                    r_d.st       = SEQ_IDLE;
                end
                default: r_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= CFG_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign mask      = r_q.mask;
    assign vec_base  = r_q.vec;
    assign edge_trig = r_q.edge_trig;
    assign cascade   = r_q.cascade;
    assign casc_cfg  = r_q.casc_cfg;
    assign auto_eoi  = r_q.auto_eoi;
    assign seq_idle  = (r_q.st == SEQ_IDLE);

endmodule

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] isr_in,
    output logic              eoi_nonspec,
    output logic              eoi_spec,
    output logic [LINE_W-1:0] eoi_line,
    output logic              sel_irr
);

    localparam ocw_regs_t OCW_RST = '{nonspec: 1'b0, spec: 1'b0,
                                      line: '0, sel_irr: 1'b1};

    ocw_regs_t r_d, r_q;
    logic [LINE_W-1:0] top_line;

    // Highest in-service line, 0 when nothing is in service
    always_comb begin
        top_line = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (isr_in[i]) begin
                top_line = i[LINE_W-1:0];
            end
        end
    end

    always_comb begin
        r_d         = r_q;
        r_d.nonspec = 1'b0;
        r_d.spec    = 1'b0;
        r_d.line    = '0;
        if (cmd_wr && !wdata[4]) begin
            if (!wdata[3]) begin
                if (wdata[7:5] == OP_EOI_ANY) begin
                    r_d.nonspec = 1'b1;
                    r_d.line    = top_line;
                end else if (wdata[7:5] == OP_EOI_LINE) begin
                    r_d.spec = 1'b1;
                    r_d.line = wdata[LINE_W-1:0];
                end
            end else if (wdata[1]) begin
                r_d.sel_irr = wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= OCW_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign eoi_nonspec = r_q.nonspec;
    assign eoi_spec    = r_q.spec;
    assign eoi_line    = r_q.line;
    assign sel_irr     = r_q.sel_irr;

endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
    import pic_cmd_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_irr,
    input  logic [DATA_W-1:0] irr_in,
    input  logic [DATA_W-1:0] isr_in,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(1);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == OFS_CMD) begin
                rdata = sel_irr ? irr_in : isr_in;
            end else if (addr == OFS_DATA) begin
                rdata = mask;
            end
        end
    end

endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import pic_cmd_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        irr_in,
    input  logic [7:0]        isr_in,
    output logic [7:0]        mask_o,
    output logic [7:0]        vec_base_o,
    output logic              edge_trig_o,
    output logic              cascade_o,
    output logic [7:0]        casc_cfg_o,
    output logic              auto_eoi_o,
    output logic              eoi_nonspec_o,
    output logic              eoi_spec_o,
    output logic [2:0]        eoi_line_o
);

    localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(1);

    logic cmd_wr, data_wr, start_wr, seq_idle, sel_irr;

    assign cmd_wr   = wr_en && (addr == OFS_CMD);
    assign data_wr  = wr_en && (addr == OFS_DATA);
    assign start_wr = cmd_wr && wdata[4];

    pic_init_seq #(.IS_MASTER(IS_MASTER)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .data_wr   (data_wr),
        .wdata     (wdata),
        .mask      (mask_o),
        .vec_base  (vec_base_o),
        .edge_trig (edge_trig_o),
        .cascade   (cascade_o),
        .casc_cfg  (casc_cfg_o),
        .auto_eoi  (auto_eoi_o),
        .seq_idle  (seq_idle)
    );

    pic_ocw_decode u_ocw (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .wdata       (wdata),
        .isr_in      (isr_in),
        .eoi_nonspec (eoi_nonspec_o),
        .eoi_spec    (eoi_spec_o),
        .eoi_line    (eoi_line_o),
        .sel_irr     (sel_irr)
    );

    pic_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .rd_en   (rd_en),
        .addr    (addr),
        .sel_irr (sel_irr),
        .irr_in  (irr_in),
        .isr_in  (isr_in),
        .mask    (mask_o),
        .rdata   (rdata)
    );

endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        mask_o,
    input logic              eoi_nonspec_o,
    input logic              eoi_spec_o,
    input logic [2:0]        eoi_line_o,
    input logic              seq_idle
);

    logic cmd_wr, data_wr;
    assign cmd_wr  = wr_en && (addr == ADDR_W'(0));
    assign data_wr = wr_en && (addr == ADDR_W'(1));

    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && seq_idle) |=> (mask_o == $past(wdata)));

    a_r3_start_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[4]) |=> (mask_o == 8'h00));

    a_r7_nonspec_cause: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_nonspec_o |-> $past(cmd_wr && wdata[7:3] == 5'b00100));

    a_r8_spec_line: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_spec_o |-> ($past(cmd_wr && wdata[7:3] == 5'b01100)
                        && eoi_line_o == $past(wdata[2:0])));

    a_r9_other_codes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[4:3] == 2'b00 && wdata[7:5] != 3'b001
         && wdata[7:5] != 3'b011) |=> (!eoi_nonspec_o && !eoi_spec_o));

endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .mask_o        (mask_o),
    .eoi_nonspec_o (eoi_nonspec_o),
    .eoi_spec_o    (eoi_spec_o),
    .eoi_line_o    (eoi_line_o),
    .seq_idle      (seq_idle)
);

// File: tb/test_pic_cmd_decoder.sv
`timescale 1ns/1ps
module test_pic_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] irr_in = '0;
    logic [7:0] isr_in = '0;

    logic [7:0] rdata, mask_o, vec_base_o, casc_cfg_o;
    logic       edge_trig_o, cascade_o, auto_eoi_o, eoi_nonspec_o, eoi_spec_o;
    logic [2:0] eoi_line_o;
    logic [7:0] s_rdata, s_mask, s_vec, s_cfg;
    logic       s_edge, s_casc, s_aeoi, s_ns, s_sp;
    logic [2:0] s_line;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pic_cmd_decoder #(.ADDR_W(2), .IS_MASTER(1'b1)) i_pic_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .mask_o(mask_o), .vec_base_o(vec_base_o), .edge_trig_o(edge_trig_o),
        .cascade_o(cascade_o), .casc_cfg_o(casc_cfg_o), .auto_eoi_o(auto_eoi_o),
        .eoi_nonspec_o(eoi_nonspec_o), .eoi_spec_o(eoi_spec_o),
        .eoi_line_o(eoi_line_o)
    );

    pic_cmd_decoder #(.ADDR_W(2), .IS_MASTER(1'b0)) i_pic_cmd_decoder_slave (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(s_rdata), .irr_in(irr_in), .isr_in(isr_in),
        .mask_o(s_mask), .vec_base_o(s_vec), .edge_trig_o(s_edge),
        .cascade_o(s_casc), .casc_cfg_o(s_cfg), .auto_eoi_o(s_aeoi),
        .eoi_nonspec_o(s_ns), .eoi_spec_o(s_sp), .eoi_line_o(s_line)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic exp_aeoi;
        irr_in = 8'h96; isr_in = 8'h21;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 mask", mask_o, 0);
        check("R1 vec", vec_base_o, 0);
        check("R1 flags", {edge_trig_o, cascade_o, auto_eoi_o}, 0);
        check("R1 cfg", casc_cfg_o, 0);
        check("R1 strobes", {eoi_nonspec_o, eoi_spec_o}, 0);
        rd(2'd0, v); check("R1 read irr", v, 8'h96);

        // R2 mask sweep
        for (int m = 0; m < 256; m++) begin
            wr(2'd1, 8'(m));
            check("R2 mask_o", mask_o, m);
            rd(2'd1, v); check("R2 read", v, m);
        end

        // R3..R6 every setup path
        exp_aeoi = 1'b0;
        for (int c = 0; c < 8; c++) begin
            logic [7:0] w1, w2;
            w1 = 8'h10 | (c[2] ? 8'h08 : 8'h00) | (c[1] ? 8'h02 : 8'h00)
                       | (c[0] ? 8'h01 : 8'h00);
            w2 = 8'(8'h5B + c * 37);
            wr(2'd1, 8'hA5);
            wr(2'd0, w1);
            if (!c[0]) exp_aeoi = 1'b0;
            check("R3 mask cleared", mask_o, 0);
            check("R3 edge", edge_trig_o, c[2]);
            check("R3 cascade", cascade_o, !c[1]);
            check("R6 aeoi at start", auto_eoi_o, exp_aeoi);
            wr(2'd1, w2);
            check("R4 vec", vec_base_o, w2 & 8'hF8);
            check("R3 word2 not mask", mask_o, 0);
            if (c[1]) begin
                check("R4 cfg cleared", casc_cfg_o, 0);
            end else begin
                wr(2'd1, 8'hC3);
                check("R5 master cfg", casc_cfg_o, 8'hC3);
                check("R5 slave cfg", s_cfg, 8'h03);
                if (c[0]) begin
                    wr(2'd1, c[2] ? 8'h02 : 8'hFD);
                    exp_aeoi = c[2];
                    check("R6 aeoi word4", auto_eoi_o, exp_aeoi);
                end
            end
            if (c[1] && c[0]) exp_aeoi = exp_aeoi;
            wr(2'd1, 8'h3C);
            check("R6 back to idle", mask_o, 8'h3C);
            check("R6 aeoi kept", auto_eoi_o, exp_aeoi);
        end

        // R4 vector base sweep
        for (int b = 0; b < 256; b++) begin
            wr(2'd0, 8'h12);
            wr(2'd1, 8'(b));
            check("R4 vec sweep", vec_base_o, b & 8'hF8);
            wr(2'd1, 8'(~b));
            check("R4 idle after word2", mask_o, (~b) & 8'hFF);
        end

        // R8 specific lines
        for (int l = 0; l < 8; l++) begin
            wr(2'd0, 8'(8'h60 | l));
            check("R8 spec strobe", {eoi_nonspec_o, eoi_spec_o}, 1);
            check("R8 line", eoi_line_o, l);
            @(negedge clk);
            check("R8 one cycle", eoi_spec_o, 0);
        end

        // R7 nonspecific over every in-service pattern
        for (int s = 0; s < 256; s++) begin
            int hi;
            hi = 0;
            for (int k = 0; k < 8; k++) if ((s >> k) & 1) hi = k;
            isr_in = 8'(s);
            wr(2'd0, 8'h20 | 8'(s & 7));
            check("R7 nonspec strobe", {eoi_nonspec_o, eoi_spec_o}, 2);
            check("R7 line", eoi_line_o, hi);
            @(negedge clk);
            check("R7 one cycle", eoi_nonspec_o, 0);
        end

        // R10 read select
        irr_in = 8'h81; isr_in = 8'h42;
        wr(2'd0, 8'h0A); rd(2'd0, v); check("R10 select isr", v, 8'h42);
        wr(2'd0, 8'h09); rd(2'd0, v); check("R10 bit1 clear keeps", v, 8'h42);
        wr(2'd0, 8'h0B); rd(2'd0, v); check("R10 select irr", v, 8'h81);
        wr(2'd0, 8'h0A);

        // R9 other command codes
        wr(2'd1, 8'h6E);
        for (int op = 0; op < 8; op++) begin
            if (op == 1 || op == 3) continue;
            wr(2'd0, 8'((op << 5) | 5));
            check("R9 no strobe", {eoi_nonspec_o, eoi_spec_o}, 0);
            rd(2'd1, v); check("R9 mask kept", v, 8'h6E);
            rd(2'd0, v); check("R9 select kept", v, 8'h42);
        end

        // R11 unsupported offsets
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h19);
        check("R11 mask kept", mask_o, 8'h6E);
        check("R11 edge kept", edge_trig_o, 0);
        check("R11 no strobe", {eoi_nonspec_o, eoi_spec_o}, 0);
        wr(2'd1, 8'h77);
        check("R11 still idle", mask_o, 8'h77);
        rd(2'd2, v); check("R11 read 2", v, 0);
        rd(2'd3, v); check("R11 read 3", v, 0);
        @(negedge clk); #1;
        check("R11 rd_en low", rdata, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule